// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block runs one conversion on an external multichannel serial ADC whose conversion is paced by an externally supplied serial clock. The user raises `start_i` with a channel number and two input-mode flags. The block drops chip select and clocks out an 8-bit command word, MSB first. It then keeps the serial clock running and watches the converter's ready strobe. After the strobe falls, it clocks in a 16-bit frame. The first 14 bits form the result and the last two are thrown away. Chip select is then released.

The serial clock comes from the system clock through a divider. It idles low and toggles only while chip select is low. If the strobe never falls, a timeout ends the transaction with an error flag. Every transaction ends with a one-cycle `done_o` pulse. The result register changes only when a transaction finishes successfully.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock and command line are low, and `busy_o`, `done_o`, `result_vld_o` and `timeout_o` are low with `result_o` zero.
- R2: The command word is 8 bits and leaves the command line MSB first, one bit per serial clock rising edge. Its layout is bit 7 = 1, bits 6:4 = `chan_i`, bit 3 = `uni_i`, bit 2 = `sgl_i`, bits 1:0 = 2'b11.
- R3: Chip select goes low on the clock edge that accepts `start_i` and stays low until the transaction ends. The serial clock is low whenever chip select is high, and chip select is high in the cycle `done_o` is high.
- R4: The serial clock period is 2*DIV_HALF system clocks, with DIV_HALF at least 2.
- R5: Result capture begins only after a falling edge on the ready strobe that occurs after the eighth command rising edge. Strobe activity during the command phase, and data present before the qualifying edge, do not affect the result.
- R6: After the qualifying strobe edge, the block takes one data bit on each of the next 16 serial clock rising edges. `result_o` is the first 14 bits, MSB first. The two trailing bits are discarded, and `result_vld_o` goes high with `timeout_o` low.
- R7: `chan_i`, `uni_i` and `sgl_i` are latched when start is accepted. A start request while `busy_o` is high is ignored.
- R8: If no qualifying strobe edge arrives within TIMEOUT serial clock rising edges after the command, the transaction ends with `timeout_o` high, `result_vld_o` low and `result_o` unchanged.
- R9: `done_o` is high for exactly one system clock per transaction. `result_o` changes only in a cycle where `done_o` is high.
- R10: While chip select is high, activity on the data and strobe inputs changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, accepted when idle |
| chan_i | input | 3 | Channel select field of the command |
| uni_i | input | 1 | Unipolar/bipolar field of the command |
| sgl_i | input | 1 | Single-ended/differential field of the command |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| result_o | output | RES_W | Last successful conversion result |
| result_vld_o | output | 1 | Last transaction produced a result |
| timeout_o | output | 1 | Last transaction ended without a strobe edge |
| adc_csn_o | output | 1 | Converter chip select, active low |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| adc_cmd_o | output | 1 | Serial command data to the converter |
| adc_dat_i | input | 1 | Serial result data from the converter |
| adc_rdy_i | input | 1 | Converter ready strobe |

## Verification
Several frame patterns are used: all ones, all zeros, an alternating pattern and random frames. Together they expose a stuck or shifted capture and a wrong choice of which two bits are dropped. The strobe edge is placed at zero, small and random delays after the command, so an early start or an off-by-one capture window gives a wrong result. Directed cases are added on top: a strobe pulse inside the command phase, a second start with inverted settings mid-transaction, a strobe that never falls, and noise on the inputs while idle. These separate the edge qualification, the setting latch, the timeout path and input masking from the normal path.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CMD_BITS = 8;
  localparam int CHAN_W   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_READ,
    ST_END
  } seq_state_e;

  // Command word: start marker, channel, polarity, input mode, external-clock mode bits
  function automatic logic [CMD_BITS-1:0] make_cmd(input logic [CHAN_W-1:0] ch,
                                                   input logic uni,
                                                   input logic sgl);
    return {1'b1, ch, uni, sgl, 2'b11};
  endfunction

endpackage

// File: rtl/adc_seq_rstsync.sv
module adc_seq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/adc_seq_sclk.sv
module adc_seq_sclk #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int PH_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [PH_W-1:0] ph_q, ph_d;
  logic            sclk_q, sclk_d;
  logic            term;

  assign term = (ph_q == PH_W'(DIV_HALF - 1));

  always_comb begin
    ph_d   = ph_q;
    sclk_d = sclk_q;
    if (!en_i) begin
      ph_d   = '0;
      sclk_d = 1'b0;
    end else if (term) begin
      ph_d   = '0;
      sclk_d = ~sclk_q;
    end else begin
      ph_d   = ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = en_i && term && !sclk_q;
  assign fall_o = en_i && term &&  sclk_q;

  AST_SCLK_LOW_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !sclk_o) else $error("serial clock did not drop after fall event"); // R4

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !sclk_o) else $error("serial clock active while disabled"); // R3

endmodule

// File: rtl/adc_seq_rx.sv
module adc_seq_rx #(
  parameter int W  = 16,
  parameter int RW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          cap_i,
  input  logic          bit_i,
  output logic [RW-1:0] data_o
);

  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (clr_i)      sh_d = '0;
    else if (cap_i) sh_d = {sh_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign data_o = sh_q[W-1 -: RW];

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !cap_i) |=> $stable(data_o)) else $error("capture changed without enable"); // R5

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int TIMEOUT  = 64,
  parameter int RES_W    = 14,
  parameter int FRAME_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        chan_i,
  input  logic              uni_i,
  input  logic              sgl_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o,
  output logic              result_vld_o,
  output logic              timeout_o,
  output logic              adc_csn_o,
  output logic              adc_sclk_o,
  output logic              adc_cmd_o,
  input  logic              adc_dat_i,
  input  logic              adc_rdy_i
);

  localparam int CNT_MAX = (TIMEOUT > FRAME_W) ? TIMEOUT : FRAME_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic rst_s;
  logic rise_en, fall_en, sclk;
  logic cap, clr;
  logic [RES_W-1:0] rx_data;

  seq_state_e           state_q, state_d;
  logic [CMD_BITS-1:0]  cmd_q, cmd_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 err_q, err_d;
  logic                 rdy_q, rdy_d;
  logic                 done_q, done_d;
  logic                 vld_q, vld_d;
  logic                 tmo_q, tmo_d;
  logic [RES_W-1:0]     res_q, res_d;
  logic                 active;

  adc_seq_rstsync #(.STAGES(2)) i_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  assign active = (state_q != ST_IDLE);

  adc_seq_sclk #(.DIV_HALF(DIV_HALF)) i_sclk (
    .clk    (clk),
    .rst_n  (rst_s),
    .en_i   (active),
    .sclk_o (sclk),
    .rise_o (rise_en),
    .fall_o (fall_en)
  );

  adc_seq_rx #(.W(FRAME_W), .RW(RES_W)) i_rx (
    .clk    (clk),
    .rst_n  (rst_s),
    .clr_i  (clr),
    .cap_i  (cap),
    .bit_i  (adc_dat_i),
    .data_o (rx_data)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    rdy_d   = 1'b0;
    cap     = 1'b0;
    clr     = 1'b0;
    done_d  = 1'b0;
    vld_d   = vld_q;
    tmo_d   = tmo_q;
    res_d   = res_q;

    // command bits advance on falling serial edges so they are stable at each rise
    if (active && fall_en) cmd_d = {cmd_q[CMD_BITS-2:0], 1'b0};

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_CMD;
          cmd_d   = make_cmd(chan_i, uni_i, sgl_i);
          cnt_d   = '0;
          err_d   = 1'b0;
          clr     = 1'b1;
        end
      end
      ST_CMD: begin
        if (rise_en) begin
          if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
            state_d = ST_WAIT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_WAIT: begin
        rdy_d = adc_rdy_i;
        if (rdy_q && !adc_rdy_i) begin
          state_d = ST_READ;
          cnt_d   = '0;
        end else if (rise_en) begin
          if (cnt_q == CNT_W'(TIMEOUT - 1)) begin
            state_d = ST_END;
            err_d   = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_READ: begin
        if (rise_en) begin
          cap = 1'b1;
          if (cnt_q == CNT_W'(FRAME_W - 1)) state_d = ST_END;
          else                              cnt_d   = cnt_q + CNT_W'(1);
        end
      end
      ST_END: begin
        // finish on a falling serial edge so the clock never leaves a runt pulse
        if (fall_en) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          vld_d   = !err_q;
          tmo_d   = err_q;
          if (!err_q) res_d = rx_data;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      rdy_q   <= 1'b0;
      done_q  <= 1'b0;
      vld_q   <= 1'b0;
      tmo_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      rdy_q   <= rdy_d;
      done_q  <= done_d;
      vld_q   <= vld_d;
      tmo_q   <= tmo_d;
      if (done_d) res_q <= res_d;
    end
  end

  assign busy_o       = active;
  assign done_o       = done_q;
  assign result_o     = res_q;
  assign result_vld_o = vld_q;
  assign timeout_o    = tmo_q;
  assign adc_csn_o    = !active;
  assign adc_sclk_o   = sclk;
  assign adc_cmd_o    = cmd_q[CMD_BITS-1];

  AST_SCLK_GATED_BY_CS: assert property (@(posedge clk) disable iff (!rst_s)
    adc_csn_o |-> !adc_sclk_o) else $error("serial clock high while deselected"); // R3

  AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_s)
    done_o |-> adc_csn_o) else $error("done while still selected"); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_s)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_s)
    !done_o |-> $stable(result_o)) else $error("result moved outside done"); // R9

  AST_TIMEOUT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_s)
    timeout_o |-> !result_vld_o) else $error("valid together with timeout"); // R8

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_o && !done_d) |=> !adc_csn_o) else $error("busy transaction dropped early"); // R7

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  localparam int DIV_HALF = 2;
  localparam int TIMEOUT  = 64;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  chan_i;
  logic        uni_i;
  logic        sgl_i;
  logic        busy_o;
  logic        done_o;
  logic [13:0] result_o;
  logic        result_vld_o;
  logic        timeout_o;
  logic        adc_csn_o;
  logic        adc_sclk_o;
  logic        adc_cmd_o;
  logic        adc_dat_i;
  logic        adc_rdy_i;

  int checks;
  int fails;
  int cyc;
  bit finished;

  adc_seq_ctrl #(.DIV_HALF(DIV_HALF), .TIMEOUT(TIMEOUT)) i_adc_seq_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .chan_i       (chan_i),
    .uni_i        (uni_i),
    .sgl_i        (sgl_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .result_vld_o (result_vld_o),
    .timeout_o    (timeout_o),
    .adc_csn_o    (adc_csn_o),
    .adc_sclk_o   (adc_sclk_o),
    .adc_cmd_o    (adc_cmd_o),
    .adc_dat_i    (adc_dat_i),
    .adc_rdy_i    (adc_rdy_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cmd(input logic [2:0] ch, input logic uni, input logic sgl);
    return {1'b1, ch, uni, sgl, 2'b11};
  endfunction

  function automatic logic [13:0] exp_res(input logic [15:0] frame);
    return frame[15:2];
  endfunction

  task automatic run_conv(input logic [2:0] ch, input logic uni, input logic sgl,
                          input logic [15:0] frame, input int dly,
                          input bit tmo, input bit busy_start, input bit early_fall);
    logic [7:0]  got;
    logic [13:0] prev_res;
    int          c0, c1, rises, waitc;
    logic        prev_sclk;
    got      = '0;
    c0       = 0;
    c1       = 0;
    prev_res = result_o;
    @(negedge clk);
    chan_i = ch; uni_i = uni; sgl_i = sgl; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(!adc_csn_o && busy_o, "R3 select after start", {adc_csn_o, busy_o}, 2'b01);
    for (int i = 0; i < 8; i++) begin
      @(posedge adc_sclk_o);
      got[7-i] = adc_cmd_o;
      if (i == 0) c0 = cyc;
      if (i == 1) c1 = cyc;
      adc_dat_i = 1'($urandom);
      if (early_fall && i == 1) adc_rdy_i = 1'b1;
      if (early_fall && i == 4) adc_rdy_i = 1'b0;
      if (busy_start && i == 2) begin
        @(negedge clk);
        start_i = 1'b1; chan_i = ~ch; uni_i = ~uni; sgl_i = ~sgl;
        @(negedge clk);
        start_i = 1'b0;
      end
    end
    chk(got == exp_cmd(ch, uni, sgl), busy_start ? "R7 latched command" : "R2 command word",
        got, exp_cmd(ch, uni, sgl));
    chk((c1 - c0) == 2 * DIV_HALF, "R4 serial period", c1 - c0, 2 * DIV_HALF);
    if (tmo) begin
      rises = 0;
      waitc = 0;
      prev_sclk = adc_sclk_o;
      while (!done_o && waitc < 5000) begin
        @(negedge clk);
        if (adc_sclk_o && !prev_sclk) rises++;
        prev_sclk = adc_sclk_o;
        adc_dat_i = 1'($urandom);
        waitc++;
      end
      chk(done_o && timeout_o && !result_vld_o, "R8 timeout flags",
          {done_o, timeout_o, result_vld_o}, 3'b110);
      chk(rises == TIMEOUT, "R8 timeout length", rises, TIMEOUT);
      chk(result_o == prev_res, "R8 result unchanged", result_o, prev_res);
    end else begin
      for (int d = 0; d < dly; d++) begin
        @(negedge adc_sclk_o);
        adc_dat_i = 1'($urandom);
      end
      @(negedge adc_sclk_o);
      adc_rdy_i = 1'b1;
      @(negedge adc_sclk_o);
      adc_rdy_i = 1'b0;
      adc_dat_i = frame[15];
      for (int b = 14; b >= 0; b--) begin
        @(negedge adc_sclk_o);
        adc_dat_i = frame[b];
      end
      waitc = 0;
      while (!done_o && waitc < 5000) begin
        @(negedge clk);
        waitc++;
      end
      adc_dat_i = 1'($urandom);
      chk(done_o && adc_csn_o, "R3 deselect at done", {done_o, adc_csn_o}, 2'b11);
      chk(result_o == exp_res(frame), early_fall ? "R5 early strobe ignored" : "R6 result",
          result_o, exp_res(frame));
      chk(result_vld_o && !timeout_o, "R6 valid flags", {result_vld_o, timeout_o}, 2'b10);
    end
    @(negedge clk);
    chk(!done_o, "R9 done single cycle", done_o, 0);
    adc_rdy_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [13:0] held;
    bit          idle_ok;
    checks = 0; fails = 0; cyc = 0; finished = 1'b0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; start_i = 1'b0; chan_i = '0; uni_i = 1'b0; sgl_i = 1'b0;
    adc_dat_i = 1'b0; adc_rdy_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(adc_csn_o && !adc_sclk_o && !adc_cmd_o && !busy_o && !done_o &&
        !result_vld_o && !timeout_o && result_o == '0, "R1 reset state",
        {adc_csn_o, adc_sclk_o, adc_cmd_o, busy_o, done_o, result_vld_o, timeout_o}, 7'b1000000);

    // R10: idle input noise
    idle_ok = 1'b1;
    held = result_o;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      adc_rdy_i = 1'($urandom);
      adc_dat_i = 1'($urandom);
      if (!adc_csn_o || adc_sclk_o || done_o || busy_o || result_o != held) idle_ok = 1'b0;
    end
    adc_rdy_i = 1'b0;
    chk(idle_ok, "R10 idle inputs ignored", idle_ok, 1);

    run_conv(3'd7, 1'b1, 1'b1, 16'hFFFF, 0, 1'b0, 1'b0, 1'b0);
    run_conv(3'd0, 1'b0, 1'b0, 16'h0000, 3, 1'b0, 1'b0, 1'b0);
    run_conv(3'd5, 1'b0, 1'b1, 16'hAAAA, 1, 1'b0, 1'b0, 1'b0);
    run_conv(3'd2, 1'b1, 1'b0, 16'hA5C3, 2, 1'b0, 1'b0, 1'b1);
    run_conv(3'd6, 1'b0, 1'b1, 16'h1237, 4, 1'b0, 1'b1, 1'b0);
    run_conv(3'd3, 1'b1, 1'b1, 16'h0000, 0, 1'b1, 1'b0, 1'b0);
    run_conv(3'd1, 1'b0, 1'b0, 16'h5A5A, 0, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 10; n++) begin
      run_conv(3'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
               int'($urandom_range(0, 12)), 1'b0, 1'($urandom_range(0, 3) == 0),
               1'($urandom_range(0, 3) == 0));
    end

    held = result_o;
    repeat (10) @(negedge clk);
    chk(result_o == held && adc_csn_o, "R9 result held while idle", result_o, held);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule